// File: doc/BRIEF.md
# Cipher Unit Control Registers

This block is the register-side front end of a DES / Triple DES cipher unit. It decodes single-cycle core-bus writes and reads for three 64-bit key registers, the chaining-vector (IV) register used in CBC mode, a key-size register and a final-block trigger register. From these it presents a key bundle and a key mode (single DES, two-key Triple DES, three-key Triple DES) to the cipher datapath. It also loads and reads back the chaining vector, emits a one-cycle final-block pulse and a later done pulse, and raises a one-cycle error pulse on illegal accesses.

Writing the first key also copies the value into the third key. Software that sets a 16-byte key size and writes only the first two keys therefore gets two-key Triple DES with no extra step. For three-key operation, software writes the first key, then the second, then the third, and the last write replaces the copy. The key registers cannot be read. The datapath drives a busy input that makes chaining-vector reads illegal while a message is in flight, and an update port through which it writes the evolving chaining value back.

Register addresses on `busAddr`: 0 key size, 1 end-of-message trigger, 2 chaining vector, 3 first key, 4 second key, 5 third key. Addresses 6 and 7 are unmapped. Read data and all pulse outputs are registered, so they appear in the cycle after the access.

Top module: `cipherRegsTop`

## Requirements
- R1: A read of address 3, 4 or 5 returns zero on `busRdData` and pulses `errIrq` for one cycle, in the cycle after the read.
- R2: A write to address 3 loads the bus value into both `key1` and `key3`, visible in the cycle after the write.
- R3: A write to address 4 changes only `key2`, and a write to address 5 changes only `key3`. Writing addresses 3, 4 and 5 in that order leaves three independent keys.
- R4: A key-size write of exactly 8, 16 or 24 sets `keyMode` to 0, 1 or 2 respectively, with no error. A read of address 0 returns 8, 16 or 24 for the current mode.
- R5: A key-size write of any other value pulses `errIrq` and leaves `keyMode` unchanged.
- R6: A write to address 1, whatever its data, produces a one-cycle `finalBlock` pulse in the next cycle.
- R7: A read of address 1 returns zero and raises no error.
- R8: A write to address 2 loads `ivOut` and pulses `ivLoad` for one cycle. A read of address 2 while `dpBusy` is low returns the current chaining value with no error.
- R9: A read of address 2 while `dpBusy` is high returns zero and pulses `errIrq`.
- R10: When `ivUpdEn` is high, `ivOut` takes `ivUpdData`. A bus write to address 2 in the same cycle takes priority.
- R11: `doneIrq` pulses one cycle after `dpDone` is seen high, and only if a final-block trigger is pending. It fires once per trigger, and a `dpDone` with no pending trigger is ignored.
- R12: Any read or write of address 6 or 7 pulses `errIrq` and returns zero for reads.
- R13: After reset, all keys and the chaining vector are zero, `keyMode` is 0 and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe, one access per cycle |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 64 | Write data |
| busRdData | output | 64 | Registered read data, valid the cycle after a read |
| dpBusy | input | 1 | Datapath is processing a message |
| dpDone | input | 1 | Datapath reports completion of the final block |
| ivUpdEn | input | 1 | Datapath chaining-value update strobe |
| ivUpdData | input | 64 | Updated chaining value from the datapath |
| key1 | output | 64 | First key |
| key2 | output | 64 | Second key |
| key3 | output | 64 | Third key |
| keyMode | output | 2 | 0 single DES, 1 two-key Triple DES, 2 three-key Triple DES |
| ivOut | output | 64 | Current chaining vector |
| ivLoad | output | 1 | One-cycle pulse after a bus write of the chaining vector |
| finalBlock | output | 1 | One-cycle final-block trigger |
| doneIrq | output | 1 | One-cycle completion pulse |
| errIrq | output | 1 | One-cycle illegal-access pulse |

## Verification
Directed sequences come first. They write the first key alone, then all three keys in order, which tells the mirroring apart from the independent third-key load. They also write each legal key size and several illegal ones, where the error pulse and the unchanged mode must both show. Chaining-vector reads are tried with the busy input both low and high, and datapath updates are made to collide with bus writes to separate the two priorities. The run ends with a long stream of mixed random accesses over every address, done strobes and updates. In that stream, back-to-back triggers and stray done strobes check the pending logic against the behavioural model.

// File: rtl/cuPkg.sv
package cuPkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_KSZ = 3'd0,
    A_EOM = 3'd1,
    A_IV  = 3'd2,
    A_K1  = 3'd3,
    A_K2  = 3'd4,
    A_K3  = 3'd5
  } regAddr_e;

  typedef enum logic [1:0] {
    KM_SINGLE = 2'd0,
    KM_TWO    = 2'd1,
    KM_THREE  = 2'd2
  } keyMode_e;

  typedef struct packed {
    logic        wrKsz;
    keyMode_e    newMode;
    logic        wrIv;
    logic        wrK1;
    logic        wrK2;
    logic        wrK3;
    logic        rdEn;
    logic        rdZero;
    logic [ADDR_W-1:0] rdAddr;
  } strobes_t;
endpackage

// File: rtl/cuCtrl.sv
module cuCtrl
  import cuPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              dpBusy,
  input  logic              dpDone,
  output strobes_t          strb,
  output logic              finalBlock,
  output logic              doneIrq,
  output logic              errIrq
);
  localparam logic [DATA_W-1:0] KSZ_8  = DATA_W'(8);
  localparam logic [DATA_W-1:0] KSZ_16 = DATA_W'(16);
  localparam logic [DATA_W-1:0] KSZ_24 = DATA_W'(24);

  logic wrErr, rdErr, kszOk, pending;
  keyMode_e decMode;

  always_comb begin
    kszOk   = 1'b1;
    decMode = KM_SINGLE;
    if (busWrData == KSZ_8)       decMode = KM_SINGLE;
    else if (busWrData == KSZ_16) decMode = KM_TWO;
    else if (busWrData == KSZ_24) decMode = KM_THREE;
    else                          kszOk   = 1'b0;
  end

  always_comb begin
    strb         = '0;
    strb.newMode = decMode;
    strb.rdAddr  = busAddr;
    strb.rdEn    = busRdEn;
    wrErr        = 1'b0;
    rdErr        = 1'b0;
    if (busWrEn) begin
      case (busAddr)
        A_KSZ:   begin strb.wrKsz = kszOk; wrErr = !kszOk; end
        A_EOM:   ;
        A_IV:    strb.wrIv = 1'b1;
        A_K1:    strb.wrK1 = 1'b1;
        A_K2:    strb.wrK2 = 1'b1;
        A_K3:    strb.wrK3 = 1'b1;
        default: wrErr = 1'b1;
      endcase
    end
    if (busRdEn) begin
      case (busAddr)
        A_KSZ, A_EOM: ;
        A_IV:    rdErr = dpBusy;
        default: rdErr = 1'b1;
      endcase
    end
    strb.rdZero = rdErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      finalBlock <= 1'b0;
      doneIrq    <= 1'b0;
      errIrq     <= 1'b0;
      pending    <= 1'b0;
    end else begin
      finalBlock <= busWrEn && (busAddr == A_EOM);
      doneIrq    <= pending && dpDone;
      pending    <= (busWrEn && (busAddr == A_EOM)) || (pending && !dpDone);
      errIrq     <= wrErr || rdErr;
    end
  end

  assert_final_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    finalBlock |-> $past(busWrEn && busAddr == A_EOM));
  assert_done_src_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> $past(dpDone));
  assert_keyread_err_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (busAddr == A_K1 || busAddr == A_K2 || busAddr == A_K3)) |=> errIrq);
  assert_bad_ksz_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_KSZ && !kszOk) |=> errIrq);
endmodule

// File: rtl/cuRegs.sv
module cuRegs
  import cuPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ivUpdEn,
  input  logic [DATA_W-1:0] ivUpdData,
  output logic [DATA_W-1:0] key1,
  output logic [DATA_W-1:0] key2,
  output logic [DATA_W-1:0] key3,
  output logic [1:0]        keyMode,
  output logic [DATA_W-1:0] ivOut,
  output logic              ivLoad,
  output logic [DATA_W-1:0] rdData
);
  keyMode_e modeQ;
  logic [DATA_W-1:0] kszView, rdMux;

  assign keyMode = modeQ;

  always_comb begin
    case (modeQ)
      KM_TWO:   kszView = DATA_W'(16);
      KM_THREE: kszView = DATA_W'(24);
      default:  kszView = DATA_W'(8);
    endcase
    case (strb.rdAddr)
      A_KSZ:   rdMux = kszView;
      A_IV:    rdMux = ivOut;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      key1   <= '0;
      key2   <= '0;
      key3   <= '0;
      modeQ  <= KM_SINGLE;
      ivOut  <= '0;
      ivLoad <= 1'b0;
      rdData <= '0;
    end else begin
      if (strb.wrK1) begin
        key1 <= wrData;
        key3 <= wrData;
      end
      if (strb.wrK2) key2 <= wrData;
      if (strb.wrK3) key3 <= wrData;
      if (strb.wrKsz) modeQ <= strb.newMode;
      if (strb.wrIv) ivOut <= wrData;
      else if (ivUpdEn) ivOut <= ivUpdData;
      ivLoad <= strb.wrIv;
      if (strb.rdEn) rdData <= strb.rdZero ? '0 : rdMux;
    end
  end

  assert_k1_mirror_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrK1 |=> (key3 == key1));
  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    keyMode != 2'd3);
  assert_k2_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrK2 |=> ($stable(key1) && $stable(key3)));
endmodule

// File: rtl/cipherRegsTop.sv
module cipherRegsTop
  import cuPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [2:0]        busAddr,
  input  logic [63:0]       busWrData,
  output logic [63:0]       busRdData,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic              ivUpdEn,
  input  logic [63:0]       ivUpdData,
  output logic [63:0]       key1,
  output logic [63:0]       key2,
  output logic [63:0]       key3,
  output logic [1:0]        keyMode,
  output logic [63:0]       ivOut,
  output logic              ivLoad,
  output logic              finalBlock,
  output logic              doneIrq,
  output logic              errIrq
);
  strobes_t strb;

  cuCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .dpBusy(dpBusy),
    .dpDone(dpDone), .strb(strb), .finalBlock(finalBlock),
    .doneIrq(doneIrq), .errIrq(errIrq)
  );

  cuRegs #(.DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .ivUpdEn(ivUpdEn), .ivUpdData(ivUpdData), .key1(key1), .key2(key2),
    .key3(key3), .keyMode(keyMode), .ivOut(ivOut), .ivLoad(ivLoad),
    .rdData(busRdData)
  );

  assert_eom_read_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 3'd1) |=> (busRdData == '0));
  assert_iv_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 3'd2 && dpBusy) |=> (errIrq && busRdData == '0));
  assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((busRdEn || busWrEn) && busAddr[2:1] == 2'b11) |=> errIrq);
endmodule

// File: tb/tb_cipherRegsTop.sv
module tb_cipherRegsTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 0, busRdEn = 0, dpBusy = 0, dpDone = 0, ivUpdEn = 0;
  logic [2:0] busAddr = '0;
  logic [63:0] busWrData = '0, ivUpdData = '0;
  logic [63:0] busRdData, key1, key2, key3, ivOut;
  logic [1:0] keyMode;
  logic ivLoad, finalBlock, doneIrq, errIrq;

  always #2.5 clk = ~clk;

  cipherRegsTop dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .dpBusy(dpBusy), .dpDone(dpDone), .ivUpdEn(ivUpdEn), .ivUpdData(ivUpdData),
    .key1(key1), .key2(key2), .key3(key3), .keyMode(keyMode), .ivOut(ivOut),
    .ivLoad(ivLoad), .finalBlock(finalBlock), .doneIrq(doneIrq), .errIrq(errIrq)
  );

  int checks = 0, errors = 0;
  // reference model state
  logic [63:0] mK1 = 0, mK2 = 0, mK3 = 0, mIv = 0, mRd = 0;
  int mMode = 0;
  bit mErr = 0, mFin = 0, mIvl = 0, mPend = 0, mDone = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 key1", key1, mK1);
    chk("R3 key2", key2, mK2);
    chk("R2 R3 key3", key3, mK3);
    chk("R4 R5 keyMode", 64'(keyMode), 64'(mMode));
    chk("R8 R10 ivOut", ivOut, mIv);
    chk("R1 R4 R7 R8 R9 R12 rdData", busRdData, mRd);
    chk("R1 R5 R9 R12 errIrq", 64'(errIrq), 64'(mErr));
    chk("R6 finalBlock", 64'(finalBlock), 64'(mFin));
    chk("R8 ivLoad", 64'(ivLoad), 64'(mIvl));
    chk("R11 doneIrq", 64'(doneIrq), 64'(mDone));
  endtask

  task automatic modelStep();
    bit e = 0;
    bit oldPend = mPend;
    if (busRdEn) begin
      case (busAddr)
        3'd0: mRd = (mMode == 2) ? 64'd24 : (mMode == 1) ? 64'd16 : 64'd8;
        3'd1: mRd = 0;
        3'd2: if (dpBusy) begin mRd = 0; e = 1; end else mRd = mIv;
        default: begin mRd = 0; e = 1; end
      endcase
    end
    if (busWrEn && busAddr == 3'd2) mIv = busWrData;
    else if (ivUpdEn) mIv = ivUpdData;
    if (busWrEn) begin
      case (busAddr)
        3'd0: if (busWrData == 8) mMode = 0;
              else if (busWrData == 16) mMode = 1;
              else if (busWrData == 24) mMode = 2;
              else e = 1;
        3'd1, 3'd2: ;
        3'd3: begin mK1 = busWrData; mK3 = busWrData; end
        3'd4: mK2 = busWrData;
        3'd5: mK3 = busWrData;
        default: e = 1;
      endcase
    end
    mErr = e;
    mFin = busWrEn && busAddr == 3'd1;
    mIvl = busWrEn && busAddr == 3'd2;
    mDone = oldPend && dpDone;
    mPend = (busWrEn && busAddr == 3'd1) || (oldPend && !dpDone);
  endtask

  task automatic cyc(bit we, bit re, logic [2:0] a, logic [63:0] d,
                     bit busy = 0, bit upd = 0, logic [63:0] ud = 0, bit dn = 0);
    busWrEn = we; busRdEn = re; busAddr = a; busWrData = d;
    dpBusy = busy; ivUpdEn = upd; ivUpdData = ud; dpDone = dn;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 key1", key1, 0); chk("R13 key3", key3, 0); chk("R13 iv", ivOut, 0);
    chk("R13 mode", 64'(keyMode), 0);
    chk("R13 pulses", {60'd0, errIrq, finalBlock, doneIrq, ivLoad}, 0);
    rstN = 1;
    @(negedge clk);
    // R2 mirror, R4 two-key
    cyc(1, 0, 3'd0, 64'd16);
    cyc(1, 0, 3'd3, 64'h1111_2222_3333_4444);
    cyc(1, 0, 3'd4, 64'h5555_6666_7777_8888);
    chk("R2 mirror key3", key3, 64'h1111_2222_3333_4444);
    // R3 three-key order
    cyc(1, 0, 3'd0, 64'd24);
    cyc(1, 0, 3'd5, 64'h9999_AAAA_BBBB_CCCC);
    chk("R3 key3 independent", key3, 64'h9999_AAAA_BBBB_CCCC);
    // R1 key reads
    for (int i = 3; i <= 5; i++) cyc(0, 1, 3'(i), 0);
    // R5 illegal sizes
    cyc(1, 0, 3'd0, 64'd12);
    cyc(1, 0, 3'd0, 64'h100_0000_0008);
    cyc(0, 1, 3'd0, 0);
    chk("R4 ksz readback", busRdData, 64'd24);
    // R6 / R11 trigger and done
    cyc(1, 0, 3'd1, 64'hDEAD_BEEF);
    cyc(0, 0, 3'd0, 0, 1);
    cyc(0, 0, 3'd0, 0, 1, 0, 0, 1);
    cyc(0, 0, 3'd0, 0, 0, 0, 0, 1);
    // R7 trigger read
    cyc(0, 1, 3'd1, 0);
    // R8 / R9 / R10 chaining vector
    cyc(1, 0, 3'd2, 64'hCAFE_F00D_0123_4567);
    cyc(0, 1, 3'd2, 0);
    cyc(0, 1, 3'd2, 0, 1);
    cyc(0, 0, 3'd0, 0, 1, 1, 64'h0BAD_0BAD_0BAD_0BAD);
    cyc(1, 0, 3'd2, 64'h7777, 0, 1, 64'h8888);
    // R12 unmapped
    cyc(1, 0, 3'd6, 64'd1);
    cyc(0, 1, 3'd7, 0);
    // mixed random stream
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] d = {$urandom, $urandom};
      int pick = $urandom_range(0, 7);
      logic [2:0] a = 3'($urandom_range(0, 7));
      if (a == 3'd0) d = (pick < 2) ? 64'd8 : (pick < 4) ? 64'd16 : (pick < 6) ? 64'd24 : 64'(pick);
      cyc(pick[0], pick[1], a, d, 1'($urandom_range(0, 1)),
          ($urandom_range(0, 3) == 0), {$urandom, $urandom}, ($urandom_range(0, 3) == 0));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule